// File: doc/BRIEF.md
# Programmable Sum-of-Products Array Core

This block is the logic core of a small programmable logic device. It takes twelve dedicated inputs and ten feedback signals. From each of these 22 signals it makes a true line and an inverted line, which gives 44 array lines. Each of 132 product terms ANDs together the lines that its connection word selects. The first 120 terms feed ten OR gates, and those gates have unequal numbers of terms. The last twelve terms are brought out directly: one enable term per output, one global preset term and one global clear term.

The connection words are held in a clocked configuration store. A host writes the store one 44-bit term word at a time, using an address, a data word and a write strobe. A single erase command opens every connection at once. Everything from the input lines to the outputs is combinational, so only the configuration store depends on the clock. The output macrocells, the pads and any programming voltage or timing sit outside this block.

Top module: `sop_array`

## Requirements
- R1: Signal index s is ded_in[s] for s from 0 to 11, and fb_in[s-12] for s from 12 to 21. Line 2s is signal s, and line 2s+1 is its inverse. Bit j of a term word set to 1 connects line j to that term.
- R2: A term with no connections evaluates to 1. After reset, every output is therefore 1.
- R3: A term connected to both lines of the same signal evaluates to 0, whatever the inputs. A sum term written with the word 0x3 (lines 0 and 1 connected) contributes nothing to its OR gate.
- R4: A term is the AND of all its connected lines, and only of those lines.
- R5: Term addresses 0 to 119 are sum terms. They go to outputs 0 to 9 in order, in groups of 8,10,12,14,16,16,14,12,10,8 terms. sum_out[k] is the OR of its group.
- R6: oe_term[k] is the term at address 120+k. preset_term is the term at address 130, and clear_term is the term at address 131.
- R7: A write with cfg_we high stores cfg_data at cfg_addr on the rising clock edge. The new value takes effect from that edge onward.
- R8: cfg_erase opens all connections in one clock edge. Erase wins over a write in the same cycle.
- R9: A write to an address of 132 or above changes nothing.
- R10: A synchronous active-low reset opens all connections, the same as an erase.
- R11: The outputs follow changes on ded_in and fb_in with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Synchronous active-low reset |
| ded_in | input | 12 | Dedicated input signals |
| fb_in | input | 10 | Feedback signals |
| cfg_we | input | 1 | Term-word write strobe |
| cfg_addr | input | 8 | Term address |
| cfg_data | input | 44 | Connection word |
| cfg_erase | input | 1 | Open all connections |
| sum_out | output | 10 | OR-gate outputs |
| oe_term | output | 10 | Per-output enable terms |
| preset_term | output | 1 | Global preset term |
| clear_term | output | 1 | Global clear term |

## Verification
The hardest thing to reach from the ports is one sum term acting on its own. After an erase, every term is open and every output sits at 1, so a lone programmed term is hidden by the others. The bench therefore first writes the dead pattern into all 132 terms. Only then does it program single terms and test group edges, line order, both polarities and combinational response. After that it runs a long random mix of sparse writes, out-of-range writes and erases, checked against a behavioural model on every clock.

// File: rtl/sop_pkg.sv
// Package for the sum-of-products array: configuration command decoding.
// Assumes: erase always has priority over a word write.
package sop_pkg;

    typedef enum logic [1:0] {
        CFG_IDLE  = 2'd0,
        CFG_WRITE = 2'd1,
        CFG_ERASE = 2'd2
    } cfg_op_e;

    // Decodes the raw strobes into one operation; erase wins over write.
    function automatic cfg_op_e cfg_decode(logic we, logic erase, logic in_range);
        if (erase)
            return CFG_ERASE;
        else if (we && in_range)
            return CFG_WRITE;
        else
            return CFG_IDLE;
    endfunction

endpackage

// File: rtl/sop_cfg_mem.sv
// Connection store: one LINES-bit word per product term.
// Assumes: synchronous active-low reset; reset and erase both open every
// connection (all zeros); a write to an address of N_TERM or above is dropped.
module sop_cfg_mem
    import sop_pkg::*;
#(
    parameter int N_TERM = 132,
    parameter int LINES  = 44,
    parameter int AW     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic                          erase,
    input  logic [AW-1:0]                 addr,
    input  logic [LINES-1:0]              wdata,
    output logic [N_TERM-1:0][LINES-1:0]  conn
);

    logic    in_range;
    cfg_op_e op;

    // Qualifies the address and decodes the command.
    always_comb begin
        in_range = (int'(addr) < N_TERM);
        op       = cfg_decode(we, erase, in_range);
    end

    // Updates the store: reset or erase opens everything, otherwise one word is written.
    always_ff @(posedge clk) begin
        if (!rst_n || op == CFG_ERASE) begin
            for (int t = 0; t < N_TERM; t++)
                conn[t] <= '0;
        end else if (op == CFG_WRITE) begin
            conn[addr] <= wdata;
        end
    end

    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !erase && int'(addr) < N_TERM) |=> (conn[$past(addr)] == $past(wdata)));

    p_oob_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !erase && int'(addr) >= N_TERM) |=> $stable(conn));

endmodule

// File: rtl/sop_line_gen.sv
// Builds the true and inverted array lines from the input signals.
// Assumes: signal s is ded[s] for s < N_DED and fb[s-N_DED] above that;
// line 2s carries signal s and line 2s+1 carries its inverse.
module sop_line_gen #(
    parameter int N_DED = 12,
    parameter int N_FB  = 10,
    localparam int N_SIG = N_DED + N_FB,
    localparam int LINES = 2 * N_SIG
) (
    input  logic [N_DED-1:0] ded,
    input  logic [N_FB-1:0]  fb,
    output logic [LINES-1:0] lines
);

    logic [N_SIG-1:0] sig;

    // Joins the dedicated and feedback signals into one index space.
    always_comb sig = {fb, ded};

    for (genvar s = 0; s < N_SIG; s++) begin : g_pair
        assign lines[2*s]   = sig[s];
        assign lines[2*s+1] = ~sig[s];
    end

endmodule

// File: rtl/sop_pterm.sv
// One product term: the AND of every line whose connection bit is set.
// Assumes: an all-open word gives 1; lines are in true/inverse pairs.
module sop_pterm #(
    parameter int LINES = 44
) (
    input  logic [LINES-1:0] lines,
    input  logic [LINES-1:0] conn,
    output logic             term
);

    // Open connections read as 1, so only connected lines can pull the term low.
    always_comb term = &(lines | ~conn);

    // Checks the pair and all-open rules against the computed term.
    always_comb begin
        if (!$isunknown(conn) && !$isunknown(lines)) begin
            logic pair_hit;
            pair_hit = 1'b0;
            for (int p = 0; p < LINES / 2; p++)
                pair_hit = pair_hit | (conn[2*p] & conn[2*p+1]);
            p_pair_false_r3: assert (!pair_hit || !term);
            p_open_true_r2:  assert ((conn != '0) || term);
        end
    end

endmodule

// File: rtl/sop_array.sv
// Programmable AND array driving a fixed OR plane of unequal groups.
// Assumes: term addresses 0..N_SUMT-1 are sum terms, grouped per output in
// order; the next N_OUT terms are enables, then the preset term, then the
// clear term. The path from the inputs to the outputs is combinational.
module sop_array #(
    parameter int N_DED = 12,
    parameter int N_OUT = 10,
    parameter int AW    = 8,
    parameter int GROUP_SIZE [N_OUT] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8},
    localparam int LINES = 2 * (N_DED + N_OUT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DED-1:0]  ded_in,
    input  logic [N_OUT-1:0]  fb_in,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [LINES-1:0]  cfg_data,
    input  logic              cfg_erase,
    output logic [N_OUT-1:0]  sum_out,
    output logic [N_OUT-1:0]  oe_term,
    output logic              preset_term,
    output logic              clear_term
);

    // First term address of output k's group.
    function automatic int grp_base(int k);
        int acc;
        acc = 0;
        for (int i = 0; i < k; i++)
            acc += GROUP_SIZE[i];
        return acc;
    endfunction

    localparam int N_SUMT  = grp_base(N_OUT);
    localparam int OE_BASE = N_SUMT;
    localparam int PRE_IDX = N_SUMT + N_OUT;
    localparam int CLR_IDX = PRE_IDX + 1;
    localparam int N_TERM  = CLR_IDX + 1;

    logic [LINES-1:0]             lines;
    logic [N_TERM-1:0][LINES-1:0] conn;
    logic [N_TERM-1:0]            term_vec;

    sop_cfg_mem #(.N_TERM(N_TERM), .LINES(LINES), .AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .erase (cfg_erase),
        .addr  (cfg_addr),
        .wdata (cfg_data),
        .conn  (conn)
    );

    sop_line_gen #(.N_DED(N_DED), .N_FB(N_OUT)) u_lines (
        .ded   (ded_in),
        .fb    (fb_in),
        .lines (lines)
    );

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        sop_pterm #(.LINES(LINES)) u_pt (
            .lines (lines),
            .conn  (conn[t]),
            .term  (term_vec[t])
        );
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_or
        localparam int B = grp_base(k);
        localparam int S = GROUP_SIZE[k];
        assign sum_out[k] = |term_vec[B+S-1:B];
        assign oe_term[k] = term_vec[OE_BASE+k];
    end

    assign preset_term = term_vec[PRE_IDX];
    assign clear_term  = term_vec[CLR_IDX];

    p_erase_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_erase |=> (&term_vec));

    p_reset_opens_r10: assert property (@(posedge clk)
        (!rst_n ##1 (!cfg_we && !cfg_erase)) |-> (&term_vec));

endmodule

// File: tb/sim_sop_array.sv
// Bench for sop_array: a behavioural model of the connection store and the
// term rules, compared with the outputs after every clock edge.
module sim_sop_array;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ded_in = '0;
    logic [9:0]  fb_in = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [43:0] cfg_data = '0;
    logic        cfg_erase = 1'b0;
    logic [9:0]  sum_out, oe_term;
    logic        preset_term, clear_term;

    int checks = 0;
    int fails  = 0;

    logic [43:0] mm [132];
    int gsize [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

    always #5 clk = ~clk;

    sop_array u0 (
        .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .fb_in(fb_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .cfg_erase(cfg_erase), .sum_out(sum_out), .oe_term(oe_term),
        .preset_term(preset_term), .clear_term(clear_term)
    );

    function automatic int base_of(int k);
        int b = 0;
        for (int i = 0; i < k; i++) b += gsize[i];
        return b;
    endfunction

    function automatic bit eval_term(int t);
        for (int s = 0; s < 22; s++) begin
            bit v = (s < 12) ? ded_in[s] : fb_in[s-12];
            if (mm[t][2*s] && !v) return 1'b0;
            if (mm[t][2*s+1] && v) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [31:0] model_out();
        logic [31:0] r = '0;
        for (int k = 0; k < 10; k++) begin
            for (int j = 0; j < gsize[k]; j++)
                if (eval_term(base_of(k) + j)) r[k] = 1'b1;
            r[10+k] = eval_term(120 + k);
        end
        r[20] = eval_term(130);
        r[21] = eval_term(131);
        return r;
    endfunction

    function automatic logic [31:0] dut_out();
        return {10'b0, clear_term, preset_term, oe_term, sum_out};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check(tag, dut_out(), model_out());
    endtask

    // One clock: the model takes the strobes in force at the edge, then outputs are compared.
    task automatic tick(string tag);
        @(posedge clk);
        if (!rst_n || cfg_erase) begin
            for (int t = 0; t < 132; t++) mm[t] = '0;
        end else if (cfg_we && cfg_addr < 132) begin
            mm[cfg_addr] = cfg_data;
        end
        #2;
        compare(tag);
    endtask

    task automatic wr(int a, logic [43:0] d, string tag);
        cfg_we = 1'b1; cfg_addr = 8'(a); cfg_data = d;
        tick(tag);
        cfg_we = 1'b0;
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] saved;
        // R10 / R2: reset opens everything, so all outputs read 1.
        tick("R10");
        tick("R10");
        rst_n = 1'b1;
        #1;
        check("R2 R10 reset", dut_out(), 32'h003F_FFFF);

        // R3: the dead pattern on every term turns all outputs off.
        for (int t = 0; t < 132; t++) wr(t, 44'h3, "R7");
        check("R3 dead", dut_out(), 32'h0);

        // R1 / R11: line 24 is fb_in[0] true, and line 25 is its inverse.
        wr(0, 44'(1) << 24, "R7");
        fb_in[0] = 1'b1; #1; check("R1 R11 fb true", {31'b0, sum_out[0]}, 32'h1);
        fb_in[0] = 1'b0; #1; check("R1 R11 fb true", {31'b0, sum_out[0]}, 32'h0);
        wr(0, 44'(1) << 25, "R7");
        #1; check("R1 fb inverse", {31'b0, sum_out[0]}, 32'h1);
        wr(0, 44'h3, "R7");

        // R4: a term on lines 0 and 2 is ded_in[0] AND ded_in[1].
        wr(112, 44'h5, "R7");
        for (int v = 0; v < 4; v++) begin
            ded_in[1:0] = 2'(v); #1;
            check("R4 and", {31'b0, sum_out[9]}, {31'b0, v == 3});
        end
        wr(112, 44'h3, "R7");

        // R5: the last term of group 4 (address 59) drives only sum_out[4]; address 60 starts group 5.
        wr(59, 44'h0, "R7");
        check("R5 group edge", dut_out(), 32'h10);
        wr(59, 44'h3, "R7");
        wr(60, 44'h0, "R7");
        check("R5 group start", dut_out(), 32'h20);
        wr(60, 44'h3, "R7");

        // R6: the enable, preset and clear term addresses.
        wr(123, 44'h0, "R7");
        wr(130, 44'h0, "R7");
        wr(131, 44'h2, "R7");
        ded_in[0] = 1'b0; #1;
        check("R6 terms", dut_out(), (32'h1 << 13) | (32'h1 << 20) | (32'h1 << 21));
        ded_in[0] = 1'b1; #1;
        check("R6 clear inverse", {31'b0, clear_term}, 32'h0);

        // R9: an out-of-range write leaves all outputs as they were.
        saved = dut_out();
        wr(140, 44'h0, "R9");
        check("R9 oob", dut_out(), saved);

        // R8: erase beats a write in the same cycle.
        cfg_erase = 1'b1;
        wr(5, 44'h3, "R8");
        cfg_erase = 1'b0;
        check("R8 erase", dut_out(), 32'h003F_FFFF);

        // Random mix of sparse writes, erases and input changes.
        for (int i = 0; i < 600; i++) begin
            ded_in = 12'($urandom);
            fb_in  = 10'($urandom);
            cfg_erase = ($urandom_range(0, 60) == 0);
            cfg_we   = 1'b1;
            cfg_addr = 8'($urandom_range(0, 150));
            cfg_data = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            tick("R5 R6 random");
            cfg_erase = 1'b0;
            cfg_we = 1'b0;
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule